// File: doc/BRIEF.md
# Programmable RGB Video Timing Generator

This block produces the raster timing for a parallel RGB panel. A register write port programs the sync pulse width, back porch, active size and front porch of each axis, a last-active-line threshold, a pixel clock divide ratio and a small control word. From these the block derives a pixel clock enable, active-low horizontal and vertical sync, a data-enable strobe and the x/y position of the current active pixel. Both axes step through the same four-segment state machine, `SEG_SYNC` then `SEG_BACK` then `SEG_ACTIVE` then `SEG_FRONT` and back to `SEG_SYNC`. Each transition fires on the axis step in which the segment counter reaches that segment's programmed value. The horizontal axis steps on every pixel clock enable. The vertical axis steps once per line, on the horizontal `SEG_FRONT` to `SEG_SYNC` wrap.

Every length is written as its value minus one. Output starts only when two enables are set. The first is an immediate run bit. The second is a request bit whose working copy is only captured at a frame boundary. A sticky frame interrupt can be raised either on entry to vertical sync or on entry to the vertical front porch. A sticky line flag marks the threshold line. Software clears either one by writing a one to the acknowledge register.

Top module: `rgb_timing_gen`

## Requirements
- R1: After reset, hsync_n and vsync_n are 1, de, pix_x, pix_y, frame_irq and line_flag are 0, and all registers are zero.
- R2: The horizontal register (offset 0) holds sync width-1 in [7:0], back porch-1 in [15:8] and front porch-1 in [23:16]. A line is sync, back porch, active, front porch, with each segment lasting its field plus one pixel.
- R3: The vertical register (offset 1) uses the same field layout, counted in lines. A frame is vertical sync, back porch, active lines, front porch.
- R4: The size register (offset 2) holds active pixels-1 in [11:0] and active lines-1 in [23:12]. de is 1 only when both axes are in their active segment. pix_x and pix_y give the zero-based active index on each axis and are 0 outside it.
- R5: hsync_n and vsync_n are low during their sync segment while video is on, and high otherwise.
- R6: The divider register (offset 5, [7:0]) holds ratio-1. pix_ce pulses once every ratio clocks, and positions advance only on pix_ce.
- R7: The divide ratio saturates at 255: a field of 255 gives a period of 255 clocks.
- R8: With irq enable (control bit 2) set, frame_irq is set on entry to vertical sync when the source bit (control bit 3) is 0, and on entry to the vertical front porch when it is 1.
- R9: Writing 1 to bit 0 of the acknowledge register (offset 6) clears frame_irq. Writing 0 there has no effect. A set event in the same cycle as the acknowledge wins.
- R10: line_flag is set when the vertical counter enters the active line whose index equals the threshold register (offset 3, [11:0]). It is sticky, cleared by writing 1 to acknowledge bit 1, and a set event wins over a same-cycle acknowledge.
- R11: Clearing the run bit (control bit 0, offset 4) blanks the outputs from the next cycle and holds both axes at their origin.
- R12: The request bit (control bit 1) is copied into a latched enable continuously while run is 0, and only at the frame wrap while run is 1. Video is on only when run and the latched enable are both 1.
- R13: With irq enable 0, no frame boundary sets frame_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 24 | Register write data |
| pix_ce | output | 1 | Pixel clock enable |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable |
| pix_x | output | 12 | Active pixel index within the line |
| pix_y | output | 12 | Active line index within the frame |
| frame_irq | output | 1 | Sticky frame interrupt pending |
| line_flag | output | 1 | Sticky line-threshold flag |

## Verification
A frame event and a software acknowledge can land on the same clock edge. The same is true of the threshold-line event and its acknowledge. The bench schedules acknowledge writes to commit exactly on the edge where vertical sync is entered, and exactly on the edge where the threshold line begins. The scoreboard expects the flag to remain set in the following cycle. Other acknowledges are placed mid-frame, so the cleared state is also observed, and a write of zero is placed while the interrupt is pending to show it is ignored.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC   = 2'd0,
        SEG_BACK   = 2'd1,
        SEG_ACTIVE = 2'd2,
        SEG_FRONT  = 2'd3
    } seg_e;

    localparam int OFF_HTIME = 0;
    localparam int OFF_VTIME = 1;
    localparam int OFF_SIZE  = 2;
    localparam int OFF_LTHR  = 3;
    localparam int OFF_CTRL  = 4;
    localparam int OFF_DIV   = 5;
    localparam int OFF_ACK   = 6;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 24,
    parameter int PORCH_W = 8,
    parameter int ACT_W   = 12,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [PORCH_W-1:0] h_sw,
    output logic [PORCH_W-1:0] h_bp,
    output logic [PORCH_W-1:0] h_fp,
    output logic [PORCH_W-1:0] v_sw,
    output logic [PORCH_W-1:0] v_bp,
    output logic [PORCH_W-1:0] v_fp,
    output logic [ACT_W-1:0]   h_act,
    output logic [ACT_W-1:0]   v_act,
    output logic [ACT_W-1:0]   lthr,
    output logic [DIV_W-1:0]   div_m1,
    output logic               run,
    output logic               req,
    output logic               irq_en,
    output logic               src_fp,
    output logic               ack_frame,
    output logic               ack_line
);
    localparam int VACT_LSB = DATA_W / 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_sw <= '0; h_bp <= '0; h_fp <= '0;
            v_sw <= '0; v_bp <= '0; v_fp <= '0;
            h_act <= '0; v_act <= '0; lthr <= '0;
            div_m1 <= '0;
            run <= 1'b0; req <= 1'b0; irq_en <= 1'b0; src_fp <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                ADDR_W'(OFF_HTIME): begin
                    h_sw <= wdata[PORCH_W-1:0];
                    h_bp <= wdata[2*PORCH_W-1:PORCH_W];
                    h_fp <= wdata[3*PORCH_W-1:2*PORCH_W];
                end
                ADDR_W'(OFF_VTIME): begin
                    v_sw <= wdata[PORCH_W-1:0];
                    v_bp <= wdata[2*PORCH_W-1:PORCH_W];
                    v_fp <= wdata[3*PORCH_W-1:2*PORCH_W];
                end
                ADDR_W'(OFF_SIZE): begin
                    h_act <= wdata[ACT_W-1:0];
                    v_act <= wdata[VACT_LSB +: ACT_W];
                end
                ADDR_W'(OFF_LTHR): lthr <= wdata[ACT_W-1:0];
                ADDR_W'(OFF_CTRL): {src_fp, irq_en, req, run} <= wdata[3:0];
                ADDR_W'(OFF_DIV):  div_m1 <= wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        ack_frame = wr_en && (addr == ADDR_W'(OFF_ACK)) && wdata[0];
        ack_line  = wr_en && (addr == ADDR_W'(OFF_ACK)) && wdata[1];
    end
endmodule

// File: rtl/rtg_clkdiv.sv
module rtg_clkdiv #(
    parameter int DIV_W     = 8,
    parameter int MAX_RATIO = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick
);
    localparam logic [DIV_W-1:0] CAP_M1 = DIV_W'(MAX_RATIO - 1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] ratio_m1;

    always_comb begin
        ratio_m1 = (div_m1 > CAP_M1) ? CAP_M1 : div_m1;
        tick     = run && (cnt >= ratio_m1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt >= ratio_m1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             step,
    input  logic [CNT_W-1:0] len_sync,
    input  logic [CNT_W-1:0] len_back,
    input  logic [CNT_W-1:0] len_act,
    input  logic [CNT_W-1:0] len_front,
    output seg_e             seg,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    seg_e             seg_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] seg_len;
    logic             last;

    always_comb begin
        seg_nx = seg;
        cnt_nx = cnt;
        unique case (seg)
            SEG_SYNC:   seg_len = len_sync;
            SEG_BACK:   seg_len = len_back;
            SEG_ACTIVE: seg_len = len_act;
            SEG_FRONT:  seg_len = len_front;
        endcase
        last = (cnt >= seg_len);
        if (step) begin
            if (last) begin
                cnt_nx = '0;
                unique case (seg)
                    SEG_SYNC:   seg_nx = SEG_BACK;
                    SEG_BACK:   seg_nx = SEG_ACTIVE;
                    SEG_ACTIVE: seg_nx = SEG_FRONT;
                    SEG_FRONT:  seg_nx = SEG_SYNC;
                endcase
            end else begin
                cnt_nx = cnt + 1'b1;
            end
        end
        wrap = step && last && (seg == SEG_FRONT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            seg <= SEG_SYNC;
            cnt <= '0;
        end else begin
            seg <= seg_nx;
            cnt <= cnt_nx;
        end
    end
endmodule

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen
    import rtg_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int PORCH_W   = 8,
    parameter int ACT_W     = 12,
    parameter int DIV_W     = 8,
    parameter int MAX_RATIO = 255,
    parameter int DATA_W    = 2 * ACT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              pix_ce,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              de,
    output logic [ACT_W-1:0]  pix_x,
    output logic [ACT_W-1:0]  pix_y,
    output logic              frame_irq,
    output logic              line_flag
);
    logic [PORCH_W-1:0] h_sw, h_bp, h_fp, v_sw, v_bp, v_fp;
    logic [ACT_W-1:0]   h_act, v_act, lthr;
    logic [DIV_W-1:0]   div_m1;
    logic run, req, irq_en, src_fp, ack_frame, ack_line;
    logic idle;

    seg_e             h_seg, v_seg;
    logic [ACT_W-1:0] h_cnt, v_cnt;
    logic             h_wrap, v_wrap;

    logic run_lat, video_on;
    logic fp_enter, frame_evt;
    logic line_match, line_match_d, line_evt;

    rtg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORCH_W(PORCH_W),
        .ACT_W(ACT_W), .DIV_W(DIV_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .h_sw(h_sw), .h_bp(h_bp), .h_fp(h_fp),
        .v_sw(v_sw), .v_bp(v_bp), .v_fp(v_fp),
        .h_act(h_act), .v_act(v_act), .lthr(lthr), .div_m1(div_m1),
        .run(run), .req(req), .irq_en(irq_en), .src_fp(src_fp),
        .ack_frame(ack_frame), .ack_line(ack_line)
    );

    rtg_clkdiv #(.DIV_W(DIV_W), .MAX_RATIO(MAX_RATIO)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div_m1(div_m1), .tick(pix_ce)
    );

    assign idle = !run;

    rtg_axis #(.CNT_W(ACT_W)) u_hax (
        .clk(clk), .rst_n(rst_n), .hold(idle), .step(pix_ce),
        .len_sync(ACT_W'(h_sw)), .len_back(ACT_W'(h_bp)),
        .len_act(h_act), .len_front(ACT_W'(h_fp)),
        .seg(h_seg), .cnt(h_cnt), .wrap(h_wrap)
    );

    rtg_axis #(.CNT_W(ACT_W)) u_vax (
        .clk(clk), .rst_n(rst_n), .hold(idle), .step(h_wrap),
        .len_sync(ACT_W'(v_sw)), .len_back(ACT_W'(v_bp)),
        .len_act(v_act), .len_front(ACT_W'(v_fp)),
        .seg(v_seg), .cnt(v_cnt), .wrap(v_wrap)
    );

    // Latched enable: follows the request while stopped, sampled at the frame wrap while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_lat <= 1'b0;
        end else if (!run || v_wrap) begin
            run_lat <= req;
        end
    end

    always_comb begin
        video_on   = run && run_lat;
        fp_enter   = h_wrap && (v_seg == SEG_ACTIVE) && (v_cnt >= v_act);
        frame_evt  = video_on && irq_en && (src_fp ? fp_enter : v_wrap);
        line_match = video_on && (v_seg == SEG_ACTIVE) && (v_cnt == lthr);
        line_evt   = line_match && !line_match_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_irq    <= 1'b0;
            line_flag    <= 1'b0;
            line_match_d <= 1'b0;
        end else begin
            line_match_d <= line_match;
            if (frame_evt)      frame_irq <= 1'b1;
            else if (ack_frame) frame_irq <= 1'b0;
            if (line_evt)       line_flag <= 1'b1;
            else if (ack_line)  line_flag <= 1'b0;
        end
    end

    always_comb begin
        hsync_n = !(video_on && (h_seg == SEG_SYNC));
        vsync_n = !(video_on && (v_seg == SEG_SYNC));
        de      = video_on && (h_seg == SEG_ACTIVE) && (v_seg == SEG_ACTIVE);
        pix_x   = (video_on && (h_seg == SEG_ACTIVE)) ? h_cnt : '0;
        pix_y   = (video_on && (v_seg == SEG_ACTIVE)) ? v_cnt : '0;
    end
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             pix_ce,
    input logic             de,
    input logic             hsync_n,
    input logic             vsync_n,
    input logic             frame_evt,
    input logic             ack_frame,
    input logic             frame_irq,
    input logic             line_evt,
    input logic             ack_line,
    input logic             line_flag,
    input logic [CNT_W-1:0] h_cnt
);
    // R4
    de_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync_n && vsync_n));

    // R11
    stop_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !de);

    // R6
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pix_ce) |=> $stable(h_cnt));

    // R9
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_evt && ack_frame) |=> frame_irq);

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_irq && !ack_frame) |=> frame_irq);

    // R10
    line_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_evt && ack_line) |=> line_flag);

    // R10
    line_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_flag && !ack_line) |=> line_flag);
endmodule

bind rgb_timing_gen rtg_chk #(.CNT_W(ACT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .pix_ce(pix_ce), .de(de),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .frame_evt(frame_evt), .ack_frame(ack_frame), .frame_irq(frame_irq),
    .line_evt(line_evt), .ack_line(ack_line), .line_flag(line_flag),
    .h_cnt(h_cnt)
);

// File: tb/rgb_timing_gen_tb.sv
module rgb_timing_gen_tb;
    localparam int CLK_HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic        pix_ce, hsync_n, vsync_n, de, frame_irq, line_flag;
    logic [11:0] pix_x, pix_y;

    int checks = 0;
    int errors = 0;
    int now = 0;
    int tcyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    typedef struct packed {
        logic hs; logic vs; logic de;
        logic [11:0] x; logic [11:0] y;
        logic irq; logic lf;
    } exp_t;
    exp_t sb_q[$];

    rgb_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pix_ce(pix_ce), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .de(de), .pix_x(pix_x), .pix_y(pix_y),
        .frame_irq(frame_irq), .line_flag(line_flag)
    );

    always #(CLK_HALF) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0d)", tag, act, exp, now);
        end
    endtask

    task automatic reg_write(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 24'(d);
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic start(input int ctrl);
        reg_write(4, ctrl);
        now = 0;
    endtask

    task automatic at_cycle(input int t, input int a, input int d);
        repeat (t - now) @(posedge clk);
        #1;
        reg_write(a, d);
        now = t + 1;
    endtask

    task automatic goto_sample(input int t);
        repeat (t - now) @(posedge clk);
        #1;
        now = t;
        @(negedge clk);
    endtask

    task automatic measure(output int p);
        p = 0;
        @(negedge clk);
        while (!pix_ce) @(negedge clk);
        do begin
            @(negedge clk);
            p++;
        end while (!pix_ce);
    endtask

    // Scoreboard monitor: compares each cycle against the next expected item
    always @(negedge clk) begin
        if (mon_on && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if ({hsync_n, vsync_n, de, pix_x, pix_y, frame_irq, line_flag} !== e) begin
                errors++;
                if (hsync_n !== e.hs)
                    $display("FAIL R2/R5 hsync_n t=%0d: actual %0d expected %0d", tcyc, hsync_n, e.hs);
                if (vsync_n !== e.vs)
                    $display("FAIL R3 vsync_n t=%0d: actual %0d expected %0d", tcyc, vsync_n, e.vs);
                if (de !== e.de)
                    $display("FAIL R4 de t=%0d: actual %0d expected %0d", tcyc, de, e.de);
                if (pix_x !== e.x || pix_y !== e.y)
                    $display("FAIL R4 pos t=%0d: actual %0d,%0d expected %0d,%0d",
                             tcyc, pix_x, pix_y, e.x, e.y);
                if (frame_irq !== e.irq)
                    $display("FAIL R8/R9 frame_irq t=%0d: actual %0d expected %0d", tcyc, frame_irq, e.irq);
                if (line_flag !== e.lf)
                    $display("FAIL R10 line_flag t=%0d: actual %0d expected %0d", tcyc, line_flag, e.lf);
            end
            tcyc++;
        end
    end

    // Driver: expected raster for 2/2/4/2 pixels and 1/1/3/1 lines, threshold line 2
    task automatic push_expected(input int n);
        bit irq = 0;
        bit lf = 0;
        for (int t = 0; t < n; t++) begin
            exp_t e;
            int hp = t % 10;
            int ln = (t / 10) % 6;
            bit set_i, set_l, clr_i, clr_l;
            e.hs  = (hp < 2) ? 1'b0 : 1'b1;
            e.vs  = (ln == 0) ? 1'b0 : 1'b1;
            e.de  = (hp >= 4 && hp <= 7 && ln >= 2 && ln <= 4);
            e.x   = (hp >= 4 && hp <= 7) ? 12'(hp - 4) : 12'd0;
            e.y   = (ln >= 2 && ln <= 4) ? 12'(ln - 2) : 12'd0;
            e.irq = irq;
            e.lf  = lf;
            sb_q.push_back(e);
            set_i = (t % 60 == 59);
            set_l = (t % 60 == 40);
            clr_i = (t == 125 || t == 179);
            clr_l = (t == 150 || t == 220);
            irq = set_i ? 1'b1 : (clr_i ? 1'b0 : irq);
            lf  = set_l ? 1'b1 : (clr_l ? 1'b0 : lf);
        end
    endtask

    initial begin
        int p;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(hsync_n === 1'b1, "R1 hsync_n", hsync_n, 1);
        check(vsync_n === 1'b1, "R1 vsync_n", vsync_n, 1);
        check(de === 1'b0, "R1 de", de, 0);
        check(pix_x === 12'd0, "R1 pix_x", pix_x, 0);
        check(pix_y === 12'd0, "R1 pix_y", pix_y, 0);
        check(frame_irq === 1'b0, "R1 frame_irq", frame_irq, 0);
        check(line_flag === 1'b0, "R1 line_flag", line_flag, 0);

        reg_write(0, 1 | (1 << 8) | (1 << 16));
        reg_write(1, 0);
        reg_write(2, (2 << 12) | 3);
        reg_write(3, 2);
        reg_write(5, 0);
        reg_write(4, 4'b0110);

        // R2 R3 R4 R5 R8 R9 R10 scoreboard run with coincident acknowledges
        push_expected(240);
        start(4'b0111);
        mon_on = 1'b1;
        at_cycle(100, 6, 0);
        at_cycle(125, 6, 1);
        at_cycle(150, 6, 2);
        at_cycle(179, 6, 1);
        at_cycle(220, 6, 2);
        while (sb_q.size() != 0) @(posedge clk);
        #1 mon_on = 1'b0;

        // R11 immediate stop
        reg_write(4, 4'b0010);
        @(negedge clk);
        check(hsync_n === 1'b1 && vsync_n === 1'b1, "R11 syncs idle", {hsync_n, vsync_n}, 3);
        check(de === 1'b0, "R11 de", de, 0);
        check(pix_x === 12'd0 && pix_y === 12'd0, "R11 position", pix_x, 0);
        reg_write(6, 3);
        @(negedge clk);
        check(frame_irq === 1'b0, "R9 ack frame", frame_irq, 0);
        check(line_flag === 1'b0, "R10 ack line", line_flag, 0);

        // R12 latched enable, R13 irq disabled
        start(4'b0011);
        at_cycle(30, 4, 4'b0001);
        goto_sample(35);
        check(de === 1'b1, "R12 still on after request clear", de, 1);
        check(pix_x === 12'd1 && pix_y === 12'd1, "R12 position", pix_x, 1);
        goto_sample(60);
        check(vsync_n === 1'b1, "R12 off at frame wrap", vsync_n, 1);
        check(frame_irq === 1'b0, "R13 no irq when disabled", frame_irq, 0);

        // R8 front porch source
        reg_write(4, 4'b1110);
        reg_write(6, 3);
        start(4'b1111);
        goto_sample(49);
        check(frame_irq === 1'b0, "R8 fp source before", frame_irq, 0);
        goto_sample(50);
        check(frame_irq === 1'b1, "R8 fp source set", frame_irq, 1);

        // R6 divider ratio 3
        reg_write(4, 4'b0010);
        reg_write(5, 2);
        start(4'b0011);
        goto_sample(5);
        check(hsync_n === 1'b0, "R6 sync held by divider", hsync_n, 0);
        goto_sample(6);
        check(hsync_n === 1'b1, "R6 sync ends after 6 clocks", hsync_n, 1);
        measure(p);
        check(p == 3, "R6 pix_ce period", p, 3);

        // R7 saturation
        reg_write(4, 4'b0010);
        reg_write(5, 255);
        start(4'b0011);
        measure(p);
        check(p == 255, "R7 saturated period", p, 255);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule